// File: doc/BRIEF.md
# LCD Row Scan Sequencer

This block drives the row scan of a passive dot-matrix panel. Each scan tick moves it to the next common row. For the current row it works out which display-RAM line belongs there, asks the RAM for the matching page, and picks one bit from every column byte. The result is a registered 61-bit segment vector and a registered one-hot common-row select.

A start-line offset scrolls the picture vertically, and a reverse flag mirrors the column-to-segment mapping. A duty flag picks a 16-row or a 32-row scan. In a 32-row panel, a second device with its bank flag set drives rows 16 to 31. Two override flags, static all-lit and display-off, replace the segment data. The alternation signal flips once per frame. A master drives it out, and a slave takes it in and uses each of its edges to restart its own row count.

Top module: `lcd_scan_seq`

## Requirements
- R1: While `rst_n` is low, `seg_out`, `com_out` and `frame_out` are all zero. The row count restarts at row 0.
- R2: Each cycle with `scan_tick` high advances the row count by one. When the count is at or above the last active row, the tick returns it to 0 instead. The last active row is 15 when `cfg_duty32`=0 and 31 when `cfg_duty32`=1.
- R3: The RAM line for row r is (`cfg_start_line` + r) mod 32. `ram_page` carries line bits [4:3]. The bit taken from each byte is line bits [2:0]. Column c's byte is `ram_rdata[8c+7:8c]`.
- R4: With `cfg_reverse`=0, segment n shows RAM column n. With `cfg_reverse`=1, segment n shows RAM column 79-n.
- R5: `com_out[i]` is high only when the row count equals 16*`cfg_upper`+i. With `cfg_duty32`=0 and `cfg_upper`=1, no bit is ever high.
- R6: With `cfg_static`=1, every segment bit is 1, whatever the RAM contents and whatever `cfg_disp_on` is.
- R7: With `cfg_static`=0 and `cfg_disp_on`=0, every segment bit is 0, whatever the RAM contents.
- R8: With `cfg_master`=1, `frame_oe` is 1. `frame_out` inverts on each tick that wraps the row count and holds on every other cycle.
- R9: With `cfg_master`=0, `frame_oe` is 0 and `frame_out` copies `frame_in` one cycle later. A change of `frame_in` sets the row count to 0, and this wins over a tick in the same cycle.
- R10: `seg_out` and `com_out` reflect the row count and the flags of the previous cycle, so they trail a tick by two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_tick | input | 1 | One-cycle pulse that advances the row |
| cfg_start_line | input | 5 | RAM line shown on row 0 |
| cfg_duty32 | input | 1 | 1: 32-row scan, 0: 16-row scan |
| cfg_reverse | input | 1 | 1: mirrored column mapping |
| cfg_disp_on | input | 1 | 0 blanks all segments |
| cfg_static | input | 1 | 1 lights all segments |
| cfg_master | input | 1 | 1: drive frame signal, 0: follow it |
| cfg_upper | input | 1 | Common bank: 0 rows 0-15, 1 rows 16-31 |
| frame_in | input | 1 | External frame alternation (slave) |
| ram_page | output | 2 | Page requested from the display RAM |
| ram_rdata | input | 640 | Page contents, 8 bits per column, combinational |
| seg_out | output | 61 | Segment vector |
| com_out | output | 16 | One-hot common-row select |
| frame_out | output | 1 | Frame alternation level |
| frame_oe | output | 1 | Drive enable for frame_out |

## Verification
A tick changes the row count on the edge that samples it. The segment and common registers pick up the new row on the edge after that. The bench therefore drives each tick for one cycle and waits one more full cycle, then samples on the falling edge. The same two-edge rule holds for flag changes, so override and mapping checks also wait one cycle after the flag is set. The frame level moves on the same edge as the row count, one edge earlier than the segments. A slave's resync shows on `com_out` two edges after `frame_in` changes.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int LINE_W = 5;
  localparam int BIT_W  = 3;
  localparam int PAGE_W = LINE_W - BIT_W;

  typedef logic [LINE_W-1:0] line_t;

  // RAM line shown on a given row; the 5-bit sum wraps at 32
  function automatic line_t scan_line(line_t start, line_t row);
    line_t s;
    s = start + row;
    return s;
  endfunction

  function automatic logic [PAGE_W-1:0] line_page(line_t l);
    return l[LINE_W-1:BIT_W];
  endfunction

  function automatic logic [BIT_W-1:0] line_bit(line_t l);
    return l[BIT_W-1:0];
  endfunction
endpackage

// File: rtl/lcd_row_ctr.sv
module lcd_row_ctr
  import lcd_scan_pkg::*;
#(
  parameter int COM_N = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  scan_tick,
  input  logic  cfg_duty32,
  input  logic  cfg_master,
  input  logic  frame_in,
  output line_t row_q,
  output logic  frame_q,
  output logic  wrap_evt,
  output logic  resync_evt
);
  localparam line_t LAST_LO = line_t'(COM_N - 1);
  localparam line_t LAST_HI = line_t'(2 * COM_N - 1);

  line_t last_row;

  always_comb begin
    last_row   = cfg_duty32 ? LAST_HI : LAST_LO;
    wrap_evt   = scan_tick && (row_q >= last_row);
    resync_evt = !cfg_master && (frame_in != frame_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      frame_q <= 1'b0;
    end else begin
      if (resync_evt)    row_q <= '0;
      else if (wrap_evt) row_q <= '0;
      else if (scan_tick) row_q <= row_q + line_t'(1);
      if (cfg_master) frame_q <= wrap_evt ? ~frame_q : frame_q;
      else            frame_q <= frame_in;
    end
  end

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> row_q == '0);
  a_r8_frame_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && wrap_evt |=> frame_q != $past(frame_q));
  a_r8_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && !wrap_evt |=> $stable(frame_q));
  a_r9_resync: assert property (@(posedge clk) disable iff (!rst_n)
    resync_evt |=> row_q == '0);
  a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |=> frame_q == $past(frame_in));
endmodule

// File: rtl/lcd_com_dec.sv
module lcd_com_dec
  import lcd_scan_pkg::*;
#(
  parameter int COM_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  line_t            row,
  input  logic             cfg_upper,
  output logic [COM_N-1:0] com_q
);
  logic [COM_N-1:0] com_next;

  always_comb begin
    for (int i = 0; i < COM_N; i++)
      com_next[i] = (row == line_t'(i + (cfg_upper ? COM_N : 0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) com_q <= '0;
    else        com_q <= com_next;
  end

  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_q));
endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
  import lcd_scan_pkg::*;
#(
  parameter int SEG_N = 61,
  parameter int COL_N = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COL_N*8-1:0] ram_rdata,
  input  logic [BIT_W-1:0]   bit_sel,
  input  logic               cfg_reverse,
  input  logic               cfg_static,
  input  logic               cfg_disp_on,
  output logic [SEG_N-1:0]   seg_q
);
  localparam int IDX_W = $clog2(COL_N * 8);

  // RAM column feeding segment n
  function automatic int seg_col(int n, logic rev);
    return rev ? (COL_N - 1 - n) : n;
  endfunction

  logic [SEG_N-1:0] gathered;
  logic [SEG_N-1:0] seg_next;

  always_comb begin
    for (int n = 0; n < SEG_N; n++) begin
      logic [IDX_W-1:0] idx;
      idx = IDX_W'(seg_col(n, cfg_reverse) * 8) + IDX_W'(bit_sel);
      gathered[n] = ram_rdata[idx];
    end
    if (cfg_static)       seg_next = '1;
    else if (!cfg_disp_on) seg_next = '0;
    else                  seg_next = gathered;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else        seg_q <= seg_next;
  end

  a_r6_static_lit: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_static |=> &seg_q);
  a_r7_off_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_static && !cfg_disp_on |=> seg_q == '0);
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int SEG_N = 61,
  parameter int COM_N = 16,
  parameter int COL_N = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_tick,
  input  logic [4:0]         cfg_start_line,
  input  logic               cfg_duty32,
  input  logic               cfg_reverse,
  input  logic               cfg_disp_on,
  input  logic               cfg_static,
  input  logic               cfg_master,
  input  logic               cfg_upper,
  input  logic               frame_in,
  output logic [1:0]         ram_page,
  input  logic [COL_N*8-1:0] ram_rdata,
  output logic [SEG_N-1:0]   seg_out,
  output logic [COM_N-1:0]   com_out,
  output logic               frame_out,
  output logic               frame_oe
);
  line_t row_q;
  line_t cur_line;
  logic  frame_q;
  logic  wrap_evt;
  logic  resync_evt;

  lcd_row_ctr #(.COM_N(COM_N)) u_row (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_tick  (scan_tick),
    .cfg_duty32 (cfg_duty32),
    .cfg_master (cfg_master),
    .frame_in   (frame_in),
    .row_q      (row_q),
    .frame_q    (frame_q),
    .wrap_evt   (wrap_evt),
    .resync_evt (resync_evt)
  );

  assign cur_line  = scan_line(line_t'(cfg_start_line), row_q);
  assign ram_page  = line_page(cur_line);
  assign frame_out = frame_q;
  assign frame_oe  = cfg_master;

  lcd_com_dec #(.COM_N(COM_N)) u_com (
    .clk       (clk),
    .rst_n     (rst_n),
    .row       (row_q),
    .cfg_upper (cfg_upper),
    .com_q     (com_out)
  );

  lcd_seg_map #(.SEG_N(SEG_N), .COL_N(COL_N)) u_seg (
    .clk         (clk),
    .rst_n       (rst_n),
    .ram_rdata   (ram_rdata),
    .bit_sel     (line_bit(cur_line)),
    .cfg_reverse (cfg_reverse),
    .cfg_static  (cfg_static),
    .cfg_disp_on (cfg_disp_on),
    .seg_q       (seg_out)
  );

  a_r10_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_duty32 && !$past(cfg_duty32) && $past(wrap_evt) |-> row_q < line_t'(COM_N));
  a_r1_reset_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_out) && cfg_master |-> $past(wrap_evt));
endmodule

// File: tb/lcd_scan_seq_tb.sv
`timescale 1ns/1ps
module lcd_scan_seq_tb;
  localparam int SEG_N = 61;
  localparam int COM_N = 16;
  localparam int COL_N = 80;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n = 0, scan_tick = 0;
  logic [4:0] cfg_start_line = 0;
  logic cfg_duty32 = 0, cfg_reverse = 0, cfg_disp_on = 1, cfg_static = 0;
  logic cfg_master = 1, cfg_upper = 0, frame_in = 0;
  logic [1:0] ram_page;
  logic [COL_N*8-1:0] ram_rdata;
  logic [SEG_N-1:0] seg_out;
  logic [COM_N-1:0] com_out;
  logic frame_out, frame_oe;

  logic [7:0] mem [0:3][0:COL_N-1];
  int n_chk = 0, n_bad = 0;
  int row_m = 0, frm_m = 0;

  lcd_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .cfg_start_line(cfg_start_line),
    .cfg_duty32(cfg_duty32), .cfg_reverse(cfg_reverse), .cfg_disp_on(cfg_disp_on),
    .cfg_static(cfg_static), .cfg_master(cfg_master), .cfg_upper(cfg_upper),
    .frame_in(frame_in), .ram_page(ram_page), .ram_rdata(ram_rdata),
    .seg_out(seg_out), .com_out(com_out), .frame_out(frame_out), .frame_oe(frame_oe)
  );

  always_comb begin
    for (int c = 0; c < COL_N; c++) ram_rdata[c*8 +: 8] = mem[ram_page][c];
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SEG_N-1:0] exp_seg(int r, int st, bit rev);
    int ln, pg, bi, col;
    logic [SEG_N-1:0] v;
    ln = (st + r) % 32;
    pg = ln / 8;
    bi = ln % 8;
    for (int n = 0; n < SEG_N; n++) begin
      col = rev ? (COL_N - 1 - n) : n;
      v[n] = mem[pg][col][bi];
    end
    return v;
  endfunction

  function automatic logic [COM_N-1:0] exp_com(int r, bit up);
    logic [COM_N-1:0] v;
    v = '0;
    for (int i = 0; i < COM_N; i++) if (r == (up ? COM_N : 0) + i) v[i] = 1'b1;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    check("R1 seg reset", 64'(seg_out), 64'd0);
    check("R1 com reset", 64'(com_out), 64'd0);
    check("R1 frame reset", 64'(frame_out), 64'd0);
    rst_n = 1;
    row_m = 0; frm_m = 0;
    @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) scan_tick = 1;
    @(negedge clk) scan_tick = 0;
    @(negedge clk);
    if (row_m >= (cfg_duty32 ? 31 : 15)) begin
      row_m = 0;
      if (cfg_master) frm_m ^= 1;
    end else row_m++;
  endtask

  task automatic check_rows(string tag);
    check({tag, " R3/R4 seg"}, 64'(seg_out), 64'(exp_seg(row_m, cfg_start_line, cfg_reverse)));
    check({tag, " R5 com"}, 64'(com_out), 64'(exp_com(row_m, cfg_upper)));
    if (cfg_master) check({tag, " R8 frame"}, 64'(frame_out), 64'(frm_m));
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < COL_N; c++)
        mem[p][c] = 8'((p * 37 + c * 13 + 5) ^ (c >> 1) ^ (p << 5));

    // R1-tagged reset, then sweeps over start line, mirror, duty and bank
    do_reset();
    for (int s = 0; s < 4; s++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        cfg_start_line = (s == 0) ? 5'd0 : (s == 1) ? 5'd8 : (s == 2) ? 5'd13 : 5'd31;
        cfg_reverse = cfg[0];
        cfg_duty32  = cfg[1];
        cfg_upper   = cfg[2];
        do_reset();
        check_rows("R10 row0");
        check("R8 frame_oe", 64'(frame_oe), 64'd1);
        for (int t = 0; t < (cfg_duty32 ? 66 : 34); t++) begin
          do_tick();
          check_rows("R2 sweep");
        end
      end
    end

    // Overrides: R6 static, R7 blank
    cfg_duty32 = 0; cfg_upper = 0; cfg_reverse = 0; cfg_start_line = 5'd3;
    do_reset();
    do_tick(); do_tick();
    @(negedge clk) cfg_static = 1;
    @(negedge clk); @(negedge clk);
    check("R6 static lit", 64'(seg_out), 64'({SEG_N{1'b1}}));
    check("R6 com unchanged", 64'(com_out), 64'(exp_com(row_m, 0)));
    @(negedge clk) cfg_disp_on = 0;
    @(negedge clk); @(negedge clk);
    check("R6 static over off", 64'(seg_out), 64'({SEG_N{1'b1}}));
    @(negedge clk) cfg_static = 0;
    @(negedge clk); @(negedge clk);
    check("R7 blank", 64'(seg_out), 64'd0);
    do_tick();
    check("R7 blank after tick", 64'(seg_out), 64'd0);
    @(negedge clk) cfg_disp_on = 1;
    @(negedge clk); @(negedge clk);
    check_rows("R7 restore");

    // Slave: R9
    cfg_master = 0; frame_in = 0;
    do_reset();
    check("R9 frame_oe", 64'(frame_oe), 64'd0);
    for (int t = 0; t < 5; t++) do_tick();
    check_rows("R9 slave run");
    @(negedge clk) frame_in = 1;
    @(negedge clk); @(negedge clk);
    row_m = 0;
    check("R9 resync com", 64'(com_out), 64'(exp_com(0, 0)));
    check("R9 frame follow", 64'(frame_out), 64'd1);
    for (int t = 0; t < 3; t++) do_tick();
    @(negedge clk) begin frame_in = 0; scan_tick = 1; end
    @(negedge clk) scan_tick = 0;
    @(negedge clk);
    row_m = 0;
    check("R9 resync beats tick", 64'(com_out), 64'(exp_com(0, 0)));
    for (int t = 0; t < 18; t++) begin
      do_tick();
      check_rows("R9 slave wrap");
      check("R9 frame held to input", 64'(frame_out), 64'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule